// File: doc/BRIEF.md
# Trap-Return Guard Clear Unit

This block decides which copies of the supervisor double-trap guard bit must be cleared when a trap-return instruction retires. The guard bit is set on entry to a supervisor trap handler; a second trap taken while it is set is escalated to machine level. Leaving the handler through a return instruction must drop the guard, but only in the status copies that the return actually leaves behind. Which copies those are depends on the kind of return and on the privilege and virtualization the hart returns to.

The pipeline presents a return-kind code together with the current privilege and virtualization, the saved return target (from the status register's previous-privilege fields) and the debug return target (from the debug control register). One cycle later the block raises a one-cycle clear strobe for the machine-level guard copy (the one behind the non-virtual supervisor status view) and/or for the guard copy in the virtual-supervisor status register. The status register logic applies these strobes. Restoring privilege, interrupt enables and the program counter is handled elsewhere.

Top module: `guard_clear_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both clear strobes are low.
- R2: With return kind 0 (no return) on a cycle, both strobes are low in the following cycle.
- R3: With return kind 1 (machine return), the machine-level strobe is high in the following cycle exactly when the saved target privilege is user (code 0) or the saved virtualization bit is 1; privilege codes are user 0, supervisor 1, machine 3.
- R4: With return kind 1, the virtual-supervisor strobe is high in the following cycle exactly when the saved target is user (code 0) with the saved virtualization bit at 1.
- R5: With return kind 3 (debug return), the strobes follow the rules of R3 and R4 applied to the debug target privilege and virtualization instead of the saved ones.
- R6: A machine return ignores the debug target and the current privilege; a debug return ignores the saved target and the current privilege.
- R7: With return kind 2 (supervisor return) executed at a current privilege other than supervisor (code 1), both strobes are low in the following cycle.
- R8: A supervisor return at supervisor privilege with current virtualization 0 raises the machine-level strobe, and raises the virtual-supervisor strobe exactly when the saved target is user (code 0) with the saved virtualization bit at 1.
- R9: A supervisor return at supervisor privilege with current virtualization 1 raises only the virtual-supervisor strobe, since the status view it writes is the virtual one.
- R10: Each strobe is a registered pulse one cycle after the qualifying return and falls in the next cycle when no further qualifying return is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_kind | input | 2 | Retiring return: 0 none, 1 machine, 2 supervisor, 3 debug |
| cur_priv | input | PRIV_W | Privilege the return executes at |
| cur_virt | input | 1 | Current virtualization state |
| saved_priv | input | PRIV_W | Return target privilege from the status register |
| saved_virt | input | 1 | Return target virtualization from the status register |
| dbg_priv | input | PRIV_W | Return target privilege from the debug control register |
| dbg_virt | input | 1 | Return target virtualization from the debug control register |
| clr_mach_o | output | 1 | Clear strobe for the machine-level guard copy |
| clr_vsup_o | output | 1 | Clear strobe for the virtual-supervisor guard copy |

## Verification
The hardest situation to reach is a supervisor return executed non-virtualized whose saved target is virtual user, the only case where a supervisor return clears both copies; equally delicate are returns whose unused target source holds values that would qualify if wrongly selected. The bench sweeps every combination of return kind, current privilege and virtualization, saved target and debug target, so these cases arise with every setting of the irrelevant fields, and it then checks that a strobe drops after an idle cycle.

// File: rtl/trapret_pkg.sv
package trapret_pkg;

    typedef enum logic [1:0] {
        RET_NONE = 2'd0,
        RET_MACH = 2'd1,
        RET_SUP  = 2'd2,
        RET_DBG  = 2'd3
    } ret_kind_e;

    localparam int PRIV_USER = 0;
    localparam int PRIV_SUP  = 1;
    localparam int PRIV_MACH = 3;

    typedef struct packed {
        logic mach;
        logic vsup;
    } clr_t;

endpackage

// File: rtl/tr_target_rule.sv
// Guard clearing rule shared by machine and debug returns: the clear
// depends only on the target privilege and virtualization.
module tr_target_rule
    import trapret_pkg::*;
#(
    parameter int PRIV_W = 2
) (
    input  logic [PRIV_W-1:0] tgt_priv,
    input  logic              tgt_virt,
    output logic              clr_mach,
    output logic              clr_vsup
);
    logic to_user;

    always_comb begin
        to_user  = (tgt_priv == PRIV_W'(PRIV_USER));
        clr_mach = to_user || tgt_virt;
        clr_vsup = to_user && tgt_virt;
    end

endmodule

// File: rtl/tr_sup_rule.sv
// Guard clearing rule for a supervisor return.
module tr_sup_rule
    import trapret_pkg::*;
#(
    parameter int PRIV_W = 2
) (
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic              cur_virt,
    input  logic [PRIV_W-1:0] tgt_priv,
    input  logic              tgt_virt,
    output logic              clr_mach,
    output logic              clr_vsup
);
    logic at_sup;
    logic to_vuser;

    always_comb begin
        at_sup   = (cur_priv == PRIV_W'(PRIV_SUP));
        to_vuser = (tgt_priv == PRIV_W'(PRIV_USER)) && tgt_virt;
        clr_mach = 1'b0;
        clr_vsup = 1'b0;
        if (at_sup) begin
            if (cur_virt) begin
                // the written status view is the virtual one
                clr_vsup = 1'b1;
            end else begin
                clr_mach = 1'b1;
                clr_vsup = to_vuser;
            end
        end
    end

endmodule

// File: rtl/guard_clear_unit.sv
module guard_clear_unit
    import trapret_pkg::*;
#(
    parameter int PRIV_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ret_kind,
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic              cur_virt,
    input  logic [PRIV_W-1:0] saved_priv,
    input  logic              saved_virt,
    input  logic [PRIV_W-1:0] dbg_priv,
    input  logic              dbg_virt,
    output logic              clr_mach_o,
    output logic              clr_vsup_o
);
    // target sources: index 0 = saved status fields, 1 = debug control
    localparam int N_SRC   = 2;
    localparam int SRC_SAV = 0;
    localparam int SRC_DBG = 1;

    logic [N_SRC-1:0][PRIV_W-1:0] src_priv;
    logic [N_SRC-1:0]             src_virt;
    logic [N_SRC-1:0]             src_cm;
    logic [N_SRC-1:0]             src_cv;
    logic                         sup_cm;
    logic                         sup_cv;
    clr_t                         clr_d;
    clr_t                         clr_q;
    ret_kind_e                    kind;

    assign src_priv[SRC_SAV] = saved_priv;
    assign src_virt[SRC_SAV] = saved_virt;
    assign src_priv[SRC_DBG] = dbg_priv;
    assign src_virt[SRC_DBG] = dbg_virt;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        tr_target_rule #(.PRIV_W(PRIV_W)) u_rule (
            .tgt_priv (src_priv[g]),
            .tgt_virt (src_virt[g]),
            .clr_mach (src_cm[g]),
            .clr_vsup (src_cv[g])
        );
    end

    tr_sup_rule #(.PRIV_W(PRIV_W)) u_sup (
        .cur_priv (cur_priv),
        .cur_virt (cur_virt),
        .tgt_priv (saved_priv),
        .tgt_virt (saved_virt),
        .clr_mach (sup_cm),
        .clr_vsup (sup_cv)
    );

    always_comb begin
        kind  = ret_kind_e'(ret_kind);
        clr_d = '0;
        unique case (kind)
            RET_MACH: begin
                clr_d.mach = src_cm[SRC_SAV];
                clr_d.vsup = src_cv[SRC_SAV];
            end
            RET_DBG: begin
                clr_d.mach = src_cm[SRC_DBG];
                clr_d.vsup = src_cv[SRC_DBG];
            end
            RET_SUP: begin
                clr_d.mach = sup_cm;
                clr_d.vsup = sup_cv;
            end
            default: clr_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= '0;
        else        clr_q <= clr_d;
    end

    assign clr_mach_o = clr_q.mach;
    assign clr_vsup_o = clr_q.vsup;

endmodule

// File: rtl/guard_clear_chk.sv
module guard_clear_chk #(
    parameter int PRIV_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        ret_kind,
    input logic [PRIV_W-1:0] cur_priv,
    input logic              cur_virt,
    input logic [PRIV_W-1:0] saved_priv,
    input logic              saved_virt,
    input logic [PRIV_W-1:0] dbg_priv,
    input logic              dbg_virt,
    input logic              clr_mach_o,
    input logic              clr_vsup_o
);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_kind == 2'd0) |=> (!clr_mach_o && !clr_vsup_o));

    // R3
    mach_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_kind == 2'd1 && (saved_priv == '0 || saved_virt)) |=> clr_mach_o);

    // R4
    mach_vsup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_kind == 2'd1 && !(saved_priv == '0 && saved_virt)) |=> !clr_vsup_o);

    // R5
    dbg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_kind == 2'd3 && dbg_priv == '0 && dbg_virt) |=> (clr_mach_o && clr_vsup_o));

    // R7
    sup_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_kind == 2'd2 && cur_priv != PRIV_W'(1)) |=> (!clr_mach_o && !clr_vsup_o));

    // R9
    sup_virt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_kind == 2'd2 && cur_priv == PRIV_W'(1) && cur_virt) |=> (clr_vsup_o && !clr_mach_o));

    // R8
    sup_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_kind == 2'd2 && cur_priv == PRIV_W'(1) && !cur_virt) |=> clr_mach_o);

    // R6
    dbg_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_kind == 2'd3 && dbg_priv != '0 && !dbg_virt) |=> (!clr_mach_o && !clr_vsup_o));

endmodule

bind guard_clear_unit guard_clear_chk #(.PRIV_W(PRIV_W)) u_guard_clear_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ret_kind   (ret_kind),
    .cur_priv   (cur_priv),
    .cur_virt   (cur_virt),
    .saved_priv (saved_priv),
    .saved_virt (saved_virt),
    .dbg_priv   (dbg_priv),
    .dbg_virt   (dbg_virt),
    .clr_mach_o (clr_mach_o),
    .clr_vsup_o (clr_vsup_o)
);

// File: tb/test_guard_clear_unit.sv
module test_guard_clear_unit;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    ret_kind = '0;
    logic [PW-1:0] cur_priv = '0;
    logic          cur_virt = 1'b0;
    logic [PW-1:0] saved_priv = '0;
    logic          saved_virt = 1'b0;
    logic [PW-1:0] dbg_priv = '0;
    logic          dbg_virt = 1'b0;
    logic          clr_mach_o;
    logic          clr_vsup_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    guard_clear_unit #(.PRIV_W(PW)) i_guard_clear_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .ret_kind   (ret_kind),
        .cur_priv   (cur_priv),
        .cur_virt   (cur_virt),
        .saved_priv (saved_priv),
        .saved_virt (saved_virt),
        .dbg_priv   (dbg_priv),
        .dbg_virt   (dbg_virt),
        .clr_mach_o (clr_mach_o),
        .clr_vsup_o (clr_vsup_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b (kind=%0d cp=%0d cv=%0b sp=%0d sv=%0b dp=%0d dv=%0b)",
                     req, act, exp, ret_kind, cur_priv, cur_virt,
                     saved_priv, saved_virt, dbg_priv, dbg_virt);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs low during reset
        check("R1 mach", clr_mach_o, 1'b0);
        check("R1 vsup", clr_vsup_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mach after", clr_mach_o, 1'b0);
        check("R1 vsup after", clr_vsup_o, 1'b0);

        // exhaustive sweep; R6 follows from the irrelevant fields varying
        for (int k = 0; k < 4; k++)
        for (int cp = 0; cp < 4; cp++)
        for (int cv = 0; cv < 2; cv++)
        for (int sp = 0; sp < 4; sp++)
        for (int sv = 0; sv < 2; sv++)
        for (int dp = 0; dp < 4; dp++)
        for (int dv = 0; dv < 2; dv++) begin
            logic em, ev;
            string rm, rv;
            int tp, tv;
            ret_kind = 2'(k); cur_priv = PW'(cp); cur_virt = 1'(cv);
            saved_priv = PW'(sp); saved_virt = 1'(sv);
            dbg_priv = PW'(dp); dbg_virt = 1'(dv);
            em = 1'b0; ev = 1'b0;
            if (k == 1 || k == 3) begin
                tp = (k == 1) ? sp : dp;
                tv = (k == 1) ? sv : dv;
                em = (tp == 0) || (tv == 1);
                ev = (tp == 0) && (tv == 1);
                rm = (k == 1) ? "R3" : "R5";
                rv = (k == 1) ? "R4" : "R5";
            end else if (k == 2) begin
                if (cp != 1) begin
                    rm = "R7"; rv = "R7";
                end else if (cv == 1) begin
                    ev = 1'b1; rm = "R9"; rv = "R9";
                end else begin
                    em = 1'b1;
                    ev = (sp == 0) && (sv == 1);
                    rm = "R8"; rv = "R8";
                end
            end else begin
                rm = "R2"; rv = "R2";
            end
            @(negedge clk);
            check(rm, clr_mach_o, em);
            check(rv, clr_vsup_o, ev);
        end

        // R10: pulse falls after an idle cycle
        ret_kind = 2'd1; saved_priv = '0; saved_virt = 1'b1;
        @(negedge clk);
        check("R10 mach high", clr_mach_o, 1'b1);
        check("R10 vsup high", clr_vsup_o, 1'b1);
        ret_kind = 2'd0;
        @(negedge clk);
        check("R10 mach low", clr_mach_o, 1'b0);
        check("R10 vsup low", clr_vsup_o, 1'b0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule